// File: doc/BRIEF.md
# Handshaked Memory Bus Interface Unit

This unit connects a processor core to a simple memory bus. Each transfer is paced by a valid-address strobe from the unit and an operation-complete acknowledge from the memory. It does not count fixed wait states. The unit holds two registers that software cannot see: an address register and a data register. When the core asks for a read or a write, the unit loads the address register and, for a write, the data register. It then puts the address on a one-way address bus and sets the direction line. After one setup cycle it raises the strobe. The strobe stays high until the memory acknowledges.

On a read, the word on the incoming data bus is captured into the data register on the acknowledge edge. On a write, the outgoing data bus carries the data register from the setup cycle onward, with its output-enable active. The bidirectional bus is modelled as separate input and output buses plus an output-enable.

A recover cycle follows every transfer. In that cycle the strobe is low and a one-cycle done pulse goes to the core. The unit is busy from the cycle after it accepts a request until the recover cycle ends. Requests that arrive while it is busy are ignored.

The sequencer has four named states:
- **IDLE**: waiting for a request.
- **SETUP**: address and direction are driven, the strobe is low.
- **STROBE**: the strobe is high, waiting for the acknowledge.
- **RECOVER**: the strobe is low and done is high.

The transitions are:
- **accept**: IDLE to SETUP, on a request.
- **launch**: SETUP to STROBE, always.
- **complete**: STROBE to RECOVER, on an acknowledge.
- **release**: RECOVER to IDLE, always.

Without a request IDLE stays in IDLE, and without an acknowledge STROBE stays in STROBE.

Top module: `membus_biu`

## Requirements
- R1: While reset is asserted and directly after it, busy, done, strobe and output-enable are low and the direction line is high (read); both hidden registers hold zero.
- R2: A request in IDLE is accepted on that clock edge. From the next cycle the address bus shows the request's address and busy is high.
- R3: The strobe is never high in the first cycle after acceptance (SETUP). It rises one cycle later, with address and direction already driven.
- R4: The strobe stays high for as long as the acknowledge is low. It falls on the first edge at which the acknowledge is sampled high.
- R5: On a read, the incoming data bus is captured into the data register on the acknowledge edge. The read-data output shows the captured word from the recover cycle onward.
- R6: On a write, the data register is loaded from the core's write data at acceptance. During SETUP and STROBE the outgoing data bus carries that word with the output-enable high.
- R7: The output-enable is high only in SETUP and STROBE of a write transfer. It is never high during a read or when the unit is idle.
- R8: Done is a one-cycle pulse in the cycle after the acknowledge edge. The strobe is low in that cycle, so it is low for at least one cycle between transfers.
- R9: A request while busy is ignored: the address register, the data register and the transfer direction are unchanged.
- R10: An acknowledge outside STROBE has no effect on state, registers or outputs.
- R11: The direction line is 1 for read and 0 for write. It is 0 only in SETUP and STROBE of a write transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core transfer request, sampled in IDLE |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Byte address of the transfer |
| core_wdata | input | DATA_W | Word to write |
| core_busy | output | 1 | A transfer is in progress |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Contents of the data register |
| bus_addr | output | ADDR_W | Outgoing address bus, from the address register |
| bus_strobe | output | 1 | Valid-address strobe |
| bus_rd | output | 1 | Direction line, 1 = read, 0 = write |
| bus_dout | output | DATA_W | Outgoing half of the data bus |
| bus_doe | output | 1 | Output-enable for bus_dout |
| bus_din | input | DATA_W | Incoming half of the data bus |
| bus_ack | input | 1 | Operation-complete acknowledge from memory |

## Verification
The in-RTL assertions check every cycle that the strobe holds until an acknowledge and then falls into a done cycle. They also check that done lasts one cycle with the strobe low, that the strobe rises only after a busy setup cycle, that the output-enable implies a write direction, and that the address register does not move while the unit is busy.

Only the bench's scenarios can show the following:
- that read data really comes from the bus at the acknowledge edge;
- that stray acknowledges in IDLE and SETUP are ignored;
- that requests made during a transfer leave the registers untouched;
- that acknowledge latencies from zero to several cycles each stretch STROBE by exactly that amount.

The bench compares against a behavioural model on every clock and checks read results against its own expected memory contents.

// File: rtl/membus_pkg.sv
package membus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } bus_state_t;
endpackage

// File: rtl/membus_seq.sv
module membus_seq
    import membus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    input  logic wr_q,
    output logic accept,
    output logic capture,
    output logic busy,
    output logic done,
    output logic strobe,
    output logic rd_line,
    output logic doe
);
    bus_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: accept, launch, complete, release
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = ST_STROBE;
            ST_STROBE:  if (ack) state_nx = ST_RECOVER;
            ST_RECOVER: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept  = 1'b0;
        capture = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        strobe  = 1'b0;
        rd_line = 1'b1;
        doe     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = req;
            end
            ST_SETUP: begin
                rd_line = ~wr_q;
                doe     = wr_q;
            end
            ST_STROBE: begin
                strobe  = 1'b1;
                rd_line = ~wr_q;
                doe     = wr_q;
                capture = ack & ~wr_q;
            end
            ST_RECOVER: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    a_r4_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !ack |=> strobe);
    a_r4_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && ack |=> !strobe && done);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !strobe ##1 !done);
    a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(busy) && !$past(strobe));
    a_r7_doe_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> !rd_line && busy);
endmodule

// File: rtl/membus_hold.sv
module membus_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              busy,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              wr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= core_addr;
            wr_q   <= core_we;
            if (core_we) data_q <= core_wdata;
        end else if (capture) begin
            data_q <= bus_din;
        end
    end

    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q) && $stable(wr_q));
    a_r6_write_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_q |=> $stable(data_q));
endmodule

// File: rtl/membus_biu.sv
module membus_biu #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_busy,
    output logic              core_done,
    output logic [DATA_W-1:0] core_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_strobe,
    output logic              bus_rd,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ack
);
    logic              accept, capture, wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    membus_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (core_req),
        .ack     (bus_ack),
        .wr_q    (wr_q),
        .accept  (accept),
        .capture (capture),
        .busy    (core_busy),
        .done    (core_done),
        .strobe  (bus_strobe),
        .rd_line (bus_rd),
        .doe     (bus_doe)
    );

    membus_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .busy       (core_busy),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .bus_din    (bus_din),
        .addr_q     (addr_q),
        .data_q     (data_q),
        .wr_q       (wr_q)
    );

    assign bus_addr   = addr_q;
    assign bus_dout   = data_q;
    assign core_rdata = data_q;
endmodule

// File: tb/membus_biu_test.sv
`timescale 1ns/1ps
module membus_biu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0;
    logic [15:0] core_addr = '0, core_wdata = '0;
    logic        core_busy, core_done, bus_strobe, bus_rd, bus_doe;
    logic [15:0] core_rdata, bus_addr, bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ack = 1'b0;

    always #2 clk = ~clk;

    membus_biu uut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_busy(core_busy),
        .core_done(core_done), .core_rdata(core_rdata), .bus_addr(bus_addr),
        .bus_strobe(bus_strobe), .bus_rd(bus_rd), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_ack(bus_ack)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // operation script
    logic        op_we[8];
    logic [15:0] op_addr[8], op_data[8];
    int          op_wait[8], op_gap[8];
    logic [15:0] mem[256];
    logic [15:0] exp_mem[256];

    // behavioural model
    int          ph;
    logic [15:0] m_addr, m_data;
    logic        m_we;

    task automatic compare();
        bit wph;
        wph = m_we && (ph == 1 || ph == 2);
        chk(core_busy == (ph != 0), "R9 busy", 32'(core_busy), 32'(ph != 0));
        chk(core_done == (ph == 3), "R8 done", 32'(core_done), 32'(ph == 3));
        chk(bus_strobe == (ph == 2), "R3/R4 strobe", 32'(bus_strobe), 32'(ph == 2));
        chk(bus_doe == wph, "R7 doe", 32'(bus_doe), 32'(wph));
        chk(bus_rd == !wph, "R11 direction", 32'(bus_rd), 32'(!wph));
        chk(bus_addr == m_addr, "R2 address", 32'(bus_addr), 32'(m_addr));
        chk(bus_dout == m_data, "R6 dout", 32'(bus_dout), 32'(m_data));
        chk(core_rdata == m_data, "R5 rdata", 32'(core_rdata), 32'(m_data));
        if (ph == 3 && !m_we)
            chk(core_rdata == exp_mem[m_addr[7:0]], "R5 read value",
                32'(core_rdata), 32'(exp_mem[m_addr[7:0]]));
    endtask

    initial begin
        int opi, gapcnt, wcnt, cyc;
        bit issue, stray, finished;
        op_we = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
        op_addr = '{16'h0010, 16'h0010, 16'hFFFE, 16'hFFFE, 16'h0003, 16'h0003, 16'h0003, 16'h0000};
        op_data = '{16'hA5A5, 16'h0, 16'h1234, 16'h0, 16'h0, 16'h0F0F, 16'h0, 16'h0};
        op_wait = '{0, 2, 5, 3, 0, 1, 0, 4};
        op_gap = '{0, 0, 2, 0, 0, 1, 0, 3};
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
            exp_mem[i] = mem[i];
        end
        ph = 0; m_addr = '0; m_data = '0; m_we = 1'b0;

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!core_busy && !core_done && !bus_strobe && !bus_doe && bus_rd,
                "R1 reset outputs", {27'd0, core_busy, core_done, bus_strobe, bus_doe, bus_rd}, 32'h1);
            chk(bus_addr == 16'h0 && core_rdata == 16'h0, "R1 reset registers",
                {bus_addr, core_rdata}, 32'h0);
        end
        rst_n = 1'b1;

        opi = 0; gapcnt = op_gap[0]; wcnt = 0; cyc = 0; finished = 0;
        while (!finished) begin
            @(negedge clk);
            cyc++;
            compare();

            // core driver
            issue = (ph == 0) && (opi < 8) && (gapcnt == 0);
            stray = (ph <= 1) && !issue && (cyc % 3 == 0);
            core_req = 1'b0;
            if (issue) begin
                core_req = 1'b1;
                core_we = op_we[opi];
                core_addr = op_addr[opi];
                core_wdata = op_data[opi];
                wcnt = op_wait[opi];
                if (op_we[opi]) exp_mem[op_addr[opi][7:0]] = op_data[opi];
            end else if ((ph == 1 || ph == 2) && opi[0]) begin
                // R9: junk request while busy
                core_req = 1'b1;
                core_we = 1'b1;
                core_addr = 16'h7777;
                core_wdata = 16'h1111;
            end else if (ph == 0 && gapcnt > 0) begin
                gapcnt--;
            end

            // memory responder; R10: stray acknowledges outside STROBE
            if (bus_strobe) begin
                if (wcnt == 0) begin
                    bus_ack = 1'b1;
                    if (bus_rd) bus_din = mem[bus_addr[7:0]];
                    else begin
                        bus_din = 16'hBEEF;
                        mem[bus_addr[7:0]] = bus_dout;
                    end
                end else begin
                    bus_ack = 1'b0;
                    bus_din = 16'hBEEF;
                    wcnt--;
                end
            end else begin
                bus_ack = stray;
                bus_din = stray ? 16'hDEAD : 16'hBEEF;
            end

            // model step
            case (ph)
                0: if (core_req) begin
                    m_addr = core_addr;
                    m_we = core_we;
                    if (core_we) m_data = core_wdata;
                    ph = 1;
                    opi++;
                    gapcnt = (opi < 8) ? op_gap[opi] : 0;
                end
                1: ph = 2;
                2: if (bus_ack) begin
                    if (!m_we) m_data = bus_din;
                    ph = 3;
                end
                default: ph = 0;
            endcase

            if (opi == 8 && ph == 0 && gapcnt == 0) begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    compare();
                end
                finished = 1;
            end
            if (cyc > 5000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish actual=%0d expected<=5000", cyc);
                finished = 1;
            end
        end

        // R6/R5 end-to-end: written words reached memory
        chk(mem[8'h10] == 16'hA5A5, "R6 memory word 0x10", 32'(mem[8'h10]), 32'hA5A5);
        chk(mem[8'hFE] == 16'h1234, "R6 memory word 0xFE", 32'(mem[8'hFE]), 32'h1234);
        chk(mem[8'h03] == 16'h0F0F, "R6 memory word 0x03", 32'(mem[8'h03]), 32'h0F0F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule